// File: doc/BRIEF.md
# GPIO Port with Prioritised Alternate-Function Pin Mux

This block is an 8-bit general-purpose I/O port on a simple synchronous register bus. Software owns a port latch and a direction register, and it can read a separate register that always shows the pin levels after synchronisation. Every pin input passes through a two-flop synchronizer. The synchronised value is the one that software reads. It is also the value returned to the SPI engine as its receive lines.

The four lowest pins can be taken over by two peripheral sources, with a fixed order of priority for each pin:

1. A PWM channel with the same index as the pin, when that channel is enabled.
2. The SPI interface, when it is enabled.
3. The GPIO registers, in every other case.

The SPI signal roles are fixed to these pins: pin 0 carries MISO, pin 1 MOSI, pin 2 SCK and pin 3 SS. A master/slave input sets which of the four SPI pins the port drives. The four upper pins are always plain GPIO.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset the latch and direction registers hold 0. With no alternate function enabled, every output enable is 0.
- R2: A bus write (bus_sel=1, bus_we=1) is stored at the next clock edge. Address 0 selects the port latch and address 1 selects the direction register. Reading address 1 returns the direction register as written.
- R3: A pin under GPIO control drives its latch bit, and its output enable equals its direction bit. This applies to pins 4 to 7 at all times, and to pins 0 to 3 when neither alternate function is active. A 1 in the direction register means output.
- R4: On pin i (i = 0 to 3), pwm_en[i]=1 makes pin_out[i] equal pwm_out[i] and pin_oe[i]=1. The SPI and GPIO settings have no effect on that pin while this holds.
- R5: On pin i (i = 0 to 3), pwm_en[i]=0 with spi_en=1 makes pin_out[i] equal spi_tx[i]. The bit order of spi_tx is [0]=MISO, [1]=MOSI, [2]=SCK, [3]=SS.
- R6: On an SPI-owned pin, spi_master=1 enables the outputs of pins 1, 2 and 3 and not pin 0. spi_master=0 enables the output of pin 0 only.
- R7: Reading address 0 returns the latch bit where the direction bit is 1. Where the direction bit is 0, it returns the synchronised pin level.
- R8: Reading address 2 returns the pin levels as sampled two clock edges earlier. A bus write to address 2 changes no register.
- R9: Reset does not clear the synchronised pin state that address 2 returns. The value stays readable while reset is held.
- R10: A write to the latch takes effect even while an alternate function owns the pin. The new value drives the pin once GPIO control returns.
- R11: spi_rx[i] carries the synchronised level of pin i for i = 0 to 3.
- R12: Address 3 reads as 0. Writes to address 3 change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 2 | Register address (0 latch, 1 direction, 2 pin input, 3 unmapped) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables |
| pwm_en | input | 4 | PWM channel enables for pins 0 to 3 |
| pwm_out | input | 4 | PWM channel outputs for pins 0 to 3 |
| spi_en | input | 1 | SPI enabled on the port |
| spi_master | input | 1 | 1 for SPI master, 0 for slave |
| spi_tx | input | 4 | SPI drive values {SS, SCK, MOSI, MISO} |
| spi_rx | output | 4 | Synchronised pin levels returned to SPI, same order |

## Verification
On every cycle the assertions check the mux outcomes:

- The PWM override on each low pin.
- The SPI enable pattern for master and slave on pin 0.
- That the upper pins' enables change only after a write to the direction register.
- That the pin-input and latch readbacks match pin levels delayed by two edges.
- That the unmapped address reads as 0.

Some behaviours depend on history rather than on a single cycle, and only the bench scenarios can show them:

- The latch keeps a value that was written while PWM owned the pin, and drives it once GPIO control returns.
- The synchronised state survives a reset.
- Writes to addresses 2 and 3 leave the other registers untouched.

Random mixes of enables, directions and pin levels then cover the priority order across all pins together.

// File: rtl/gpio_altmux_port.sv
module gpio_altmux_port #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic [3:0]        pwm_en,
  input  logic [3:0]        pwm_out,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [3:0]        spi_tx,
  output logic [3:0]        spi_rx
);
  localparam int ALT_W = 4;
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(2);

  logic [PORT_W-1:0] latch_q, dir_q, meta_q, sync_q;
  logic wr;

  assign wr = bus_sel & bus_we;

  always_ff @(posedge clk) begin
    meta_q <= pin_in;
    sync_q <= meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      if (bus_addr == A_LATCH) latch_q <= bus_wdata;
      if (bus_addr == A_DIR)   dir_q   <= bus_wdata;
    end
  end

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (i < ALT_W) begin : g_alt
        localparam bit DRV_AS_MASTER = (i != 0);
        assign pin_out[i] = pwm_en[i] ? pwm_out[i] :
                            spi_en    ? spi_tx[i]  : latch_q[i];
        assign pin_oe[i]  = pwm_en[i] ? 1'b1 :
                            spi_en    ? (spi_master == DRV_AS_MASTER) : dir_q[i];
      end else begin : g_gpio
        assign pin_out[i] = latch_q[i];
        assign pin_oe[i]  = dir_q[i];
      end
    end
  endgenerate

  assign spi_rx = sync_q[ALT_W-1:0];

  always_comb begin
    case (bus_addr)
      A_LATCH: bus_rdata = (latch_q & dir_q) | (sync_q & ~dir_q);
      A_DIR:   bus_rdata = dir_q;
      A_PINS:  bus_rdata = sync_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_altmux_port_chk.sv
module gpio_altmux_port_chk #(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [PORT_W-1:0] pin_in,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [3:0]        pwm_en,
  input logic [3:0]        pwm_out,
  input logic              spi_en,
  input logic              spi_master,
  input logic [PORT_W-1:0] dir_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_PWM_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en & ~pin_oe[3:0]) == 4'h0); // R4
  AST_PWM_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en & (pin_out[3:0] ^ pwm_out)) == 4'h0); // R4
  AST_SPI_PIN0_SLAVE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en[0] && spi_en) |-> (pin_oe[0] == !spi_master)); // R6
  AST_UPPER_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !$stable(pin_oe[PORT_W-1:4]))
      |-> $past(bus_sel && bus_we && bus_addr == ADDR_W'(1))); // R3
  AST_PIN_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_addr == ADDR_W'(2)) |-> (bus_rdata == $past(pin_in, 2))); // R8
  AST_LATCH_READ_INPUT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && bus_addr == ADDR_W'(0))
      |-> (((bus_rdata ^ $past(pin_in, 2)) & ~dir_q) == '0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(3)) |-> (bus_rdata == '0)); // R12
endmodule

bind gpio_altmux_port gpio_altmux_port_chk #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .pwm_en(pwm_en), .pwm_out(pwm_out),
  .spi_en(spi_en), .spi_master(spi_master), .dir_q(dir_q)
);

// File: tb/gpio_altmux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_altmux_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata, pin_in = 8'h00, pin_out, pin_oe;
  logic [3:0] pwm_en = 4'h0, pwm_out = 4'h0, spi_tx = 4'h0, spi_rx;
  logic spi_en = 1'b0, spi_master = 1'b0;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_latch = 8'h00, m_dir = 8'h00;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_altmux_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pwm_en(pwm_en), .pwm_out(pwm_out), .spi_en(spi_en),
    .spi_master(spi_master), .spi_tx(spi_tx), .spi_rx(spi_rx)
  );

  function automatic logic [7:0] exp_out();
    logic [7:0] r = m_latch;
    for (int i = 0; i < 4; i++)
      if (pwm_en[i]) r[i] = pwm_out[i];
      else if (spi_en) r[i] = spi_tx[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r = m_dir;
    for (int i = 0; i < 4; i++)
      if (pwm_en[i]) r[i] = 1'b1;
      else if (spi_en) r[i] = (i == 0) ? !spi_master : spi_master;
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (a == 2'd0) m_latch = d;
    if (a == 2'd1) m_dir = d;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic check_all(string tag);
    logic [7:0] r;
    check({tag, " R3/R4/R5 pin_out"}, pin_out, exp_out());
    check({tag, " R3/R4/R6 pin_oe"}, pin_oe, exp_oe());
    bus_read(2'd0, r); check({tag, " R7 latch read"}, r, (m_latch & m_dir) | (pin_in & ~m_dir));
    bus_read(2'd1, r); check({tag, " R2 dir read"}, r, m_dir);
    bus_read(2'd2, r); check({tag, " R8 pin read"}, r, pin_in);
    bus_read(2'd3, r); check({tag, " R12 unmapped read"}, r, 8'h00);
    check({tag, " R11 spi_rx"}, {4'h0, spi_rx}, {4'h0, pin_in[3:0]});
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    void'($urandom(32'd1234));
    pin_in = 8'hA5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_read(2'd1, r); check("R1 dir after reset", r, 8'h00);
    check("R1 oe after reset", pin_oe, 8'h00);
    bus_read(2'd0, r); check("R1 latch read is pins", r, 8'hA5);

    // R2 write then read back next cycle
    bus_write(2'd1, 8'hF0);
    bus_read(2'd1, r); check("R2 dir write", r, 8'hF0);
    bus_write(2'd0, 8'h5A);
    check_all("dir");

    // R8 write to input register ignored
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, r); check("R8 input reg write ignored", r, 8'hA5);
    check_all("after addr2 write");

    // R12 write to unmapped ignored
    bus_write(2'd3, 8'hFF);
    bus_read(2'd0, r); check("R12 latch untouched", r, (8'h5A & 8'hF0) | (8'hA5 & 8'h0F));
    bus_read(2'd1, r); check("R12 dir untouched", r, 8'hF0);

    // R10 latch updated while PWM owns pin 1
    bus_write(2'd1, 8'h0F);
    @(negedge clk); pwm_en = 4'b0010; pwm_out = 4'b0000;
    bus_write(2'd0, 8'h02);
    check("R10 pwm holds pin", {7'h0, pin_out[1]}, 8'h00);
    @(negedge clk); pwm_en = 4'h0;
    #1; check("R10 latch value after release", {7'h0, pin_out[1]}, 8'h01);

    // R6 SPI master vs slave
    @(negedge clk); spi_en = 1'b1; spi_master = 1'b1; spi_tx = 4'b1010;
    #1; check("R6 master oe", pin_oe[3:0], 4'b1110);
    check("R5 spi data", pin_out[3:0], 4'b1010);
    spi_master = 1'b0;
    #1; check("R6 slave oe", pin_oe[3:0], 4'b0001);
    pwm_en = 4'b1000; pwm_out = 4'b0000;
    #1; check("R4 pwm over spi", {pin_oe[3], pin_out[3]}, 8'h02);
    pwm_en = 4'h0; spi_en = 1'b0;

    // R9 synchronised state survives reset
    @(negedge clk); pin_in = 8'h3C;
    settle();
    rst_n = 1'b0; m_latch = 8'h00; m_dir = 8'h00;
    repeat (2) @(negedge clk);
    bus_read(2'd2, r); check("R9 pins during reset", r, 8'h3C);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd2, r); check("R9 pins after reset", r, 8'h3C);
    check("R1 oe after second reset", pin_oe, 8'h00);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      pin_in = 8'($urandom); pwm_en = 4'($urandom); pwm_out = 4'($urandom);
      spi_en = 1'($urandom); spi_master = 1'($urandom); spi_tx = 4'($urandom);
      if ($urandom_range(0, 3) == 0) bus_write(2'($urandom_range(0, 3)), 8'($urandom));
      settle();
      check_all("random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule